// File: doc/BRIEF.md
# Inverter Gate Protection Sequencer

This block stands between the six active-high PWM commands of a three-phase inverter bridge and the six gate enables that drive the switches. It passes each command through to its gate. It blocks gates when a protection condition is present, and it drives an active-low fault line that upstream control can monitor. Dead-time insertion, PWM generation and analog sensing take place outside the block. The block sees only a digital overcurrent flag for the low-side DC bus and digitised supply codes for the low-side rail and for each high-side bootstrap rail.

Short-circuit protection covers only the three low-side switches. The overcurrent flag must hold for a programmable run of cycles before it counts. A confirmed event turns off all three low-side gates together and starts a fault pulse of fixed width. A low-side under-voltage uses a trip level and a higher release level. It also blocks the low-side gates and holds the fault line for the whole event, never for less than the fixed width. A high-side under-voltage turns off only its own phase's upper gate and leaves the fault line alone. Any gate that protection has turned off, or that reset has cleared, turns on again only after a fresh low-to-high transition of its command.

Top module: `inv_gate_guard`

## Requirements
- R1: With no protection active and the channel armed, each gate enable equals its PWM command (1 = switch on), delayed by exactly one clock cycle.
- R2: The overcurrent flag counts as a trip only after it has been 1 for FILT_CYC consecutive clock samples. A shorter run changes no output.
- R3: One cycle after a trip is confirmed (FILT_CYC+1 cycles after the flag first rises), all three low-side gates are 0. The high-side gates are unaffected.
- R4: After a trip, a low-side gate stays 0 while its command is held at 1. It turns on only after the command goes to 0 and then back to 1.
- R5: A trip drives fault_n to 0 for exactly PULSE_CYC cycles. The pulse starts on the same cycle that the low-side gates turn off.
- R6: A second confirmed trip while a fault pulse is running does not lengthen that pulse.
- R7: Low-side under-voltage sets when the supply code is below LO_TRIP and clears only when the code is above LO_REL. Codes between the two keep the current state.
- R8: While low-side under-voltage is set, all low-side gates are 0 and fault_n is 0. For a dip of one cycle, fault_n stays 0 for PULSE_CYC+1 cycles.
- R9: After the low-side supply recovers, a gate whose command is still 1 stays 0 until the next rising edge of its command.
- R10: Each high-side phase has its own under-voltage state, which sets below HI_TRIP and clears above HI_REL. While that state is set, only that phase's upper gate is 0 and fault_n stays 1.
- R11: Under synchronous reset, all gates are 0 and fault_n is 1. After reset, a command already held at 1 does not turn its gate on until it has gone to 0 and back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_hi | input | 3 | High-side PWM commands, bit i = phase i |
| pwm_lo | input | 3 | Low-side PWM commands, bit i = phase i |
| oc_in | input | 1 | Low-side bus overcurrent flag |
| vd_lo | input | CW | Low-side supply code |
| vd_hi | input | 3*CW | High-side supply codes, phase i in bits [i*CW +: CW] |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The hardest case to reach from the ports is a second short-circuit event that lands entirely inside a running fault pulse. The bench builds a schedule cycle by cycle: the first overcurrent run, a short gap, then a second run long enough to pass the filter, all timed to finish before the first pulse ends. It counts the low cycles of fault_n across the whole window. The under-voltage hysteresis needs the opposite starting state for each half of its check. The bench therefore sweeps every code of one high-side phase twice, once from the released state and once after a forced trip. It uses re-arming of the command to show whether the lockout has cleared.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  // next state of a two-threshold under-voltage latch
  function automatic logic uv_step(logic cur, int unsigned code,
                                   int unsigned trip, int unsigned rel);
    if (cur) return !(code > rel);
    return code < trip;
  endfunction

  // saturating increment
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // countdown that stops at zero
  function automatic int unsigned dec0(int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction
endpackage

// File: rtl/ipg_oc_filter.sv
module ipg_oc_filter #(
  parameter int FILT_CYC = 350
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_in,
  output logic sc_active
);
  localparam int CNTW = $clog2(FILT_CYC + 1);
  localparam logic [CNTW-1:0] LIM = CNTW'(FILT_CYC);

  logic [CNTW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (oc_in) run_q <= CNTW'(ipg_pkg::sat_inc(32'(run_q), FILT_CYC));
    else run_q <= '0;
  end

  assign sc_active = (run_q == LIM);

  AST_SC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !oc_in |=> !sc_active); // R2
  AST_SC_ROSE_ON_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(sc_active) |-> $past(oc_in)); // R2
endmodule

// File: rtl/ipg_uv_hyst.sv
module ipg_uv_hyst #(
  parameter int CW   = 8,
  parameter int TRIP = 100,
  parameter int REL  = 110
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] code,
  output logic          uv
);
  localparam logic [CW-1:0] TRIP_C = CW'(TRIP);
  localparam logic [CW-1:0] REL_C  = CW'(REL);

  always_ff @(posedge clk) begin
    if (rst) uv <= 1'b0;
    else uv <= ipg_pkg::uv_step(uv, 32'(code), TRIP, REL);
  end

  AST_UV_SET_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(uv) |-> ($past(code) < TRIP_C)); // R7
  AST_UV_CLR_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(uv) |-> ($past(code) > REL_C)); // R7
endmodule

// File: rtl/ipg_gate_chan.sv
module ipg_gate_chan (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic block,
  output logic en
);
  logic prev_q;
  logic fresh;

  assign fresh = cmd & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1; // a held command is not a fresh edge
      en     <= 1'b0;
    end else begin
      prev_q <= cmd;
      if (block)      en <= 1'b0;
      else if (fresh) en <= 1'b1;
      else if (!cmd)  en <= 1'b0;
    end
  end

  AST_BLOCK_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    block |=> !en); // R3
  AST_CMD_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    !cmd |=> !en); // R1
  AST_ON_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> ($past(cmd) && !$past(prev_q))); // R4
endmodule

// File: rtl/ipg_fault_timer.sv
module ipg_fault_timer #(
  parameter int PULSE_CYC = 480000
) (
  input  logic clk,
  input  logic rst,
  input  logic sc_active,
  input  logic uv_lo,
  output logic fault_n
);
  localparam int TW = $clog2(PULSE_CYC + 1);

  logic [TW-1:0] tmr_q;
  logic sc_q, uv_q;
  logic sc_rise, uv_rise, busy;

  assign sc_rise = sc_active & ~sc_q;
  assign uv_rise = uv_lo & ~uv_q;
  assign busy    = (tmr_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
      sc_q  <= 1'b0;
      uv_q  <= 1'b0;
    end else begin
      sc_q <= sc_active;
      uv_q <= uv_lo;
      if (uv_rise || (sc_rise && !busy)) tmr_q <= TW'(PULSE_CYC);
      else tmr_q <= TW'(ipg_pkg::dec0(32'(tmr_q)));
    end
  end

  assign fault_n = ~(busy | uv_lo);

  AST_PULSE_NO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    (busy && !uv_rise) |=> (tmr_q < $past(tmr_q))); // R6
endmodule

// File: rtl/inv_gate_guard.sv
module inv_gate_guard #(
  parameter int CW        = 8,
  parameter int FILT_CYC  = 350,
  parameter int PULSE_CYC = 480000,
  parameter int LO_TRIP   = 104,
  parameter int LO_REL    = 110,
  parameter int HI_TRIP   = 100,
  parameter int HI_REL    = 106
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      pwm_hi,
  input  logic [2:0]      pwm_lo,
  input  logic            oc_in,
  input  logic [CW-1:0]   vd_lo,
  input  logic [3*CW-1:0] vd_hi,
  output logic [2:0]      gate_hi,
  output logic [2:0]      gate_lo,
  output logic            fault_n
);
  localparam int NPH = 3;

  // named internal events
  logic           sc_active;
  logic           uv_lo;
  logic [NPH-1:0] uv_hi;
  logic           lo_block;

  ipg_oc_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst(rst), .oc_in(oc_in), .sc_active(sc_active));

  ipg_uv_hyst #(.CW(CW), .TRIP(LO_TRIP), .REL(LO_REL)) u_uv_lo (
    .clk(clk), .rst(rst), .code(vd_lo), .uv(uv_lo));

  assign lo_block = sc_active | uv_lo;

  ipg_fault_timer #(.PULSE_CYC(PULSE_CYC)) u_flt (
    .clk(clk), .rst(rst), .sc_active(sc_active), .uv_lo(uv_lo),
    .fault_n(fault_n));

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    ipg_uv_hyst #(.CW(CW), .TRIP(HI_TRIP), .REL(HI_REL)) u_uv_hi (
      .clk(clk), .rst(rst), .code(vd_hi[i*CW +: CW]), .uv(uv_hi[i]));

    ipg_gate_chan u_hi (
      .clk(clk), .rst(rst), .cmd(pwm_hi[i]), .block(uv_hi[i]),
      .en(gate_hi[i]));

    ipg_gate_chan u_lo (
      .clk(clk), .rst(rst), .cmd(pwm_lo[i]), .block(lo_block),
      .en(gate_lo[i]));
  end

  AST_SC_ALL_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    sc_active |=> (gate_lo == 3'b000)); // R3
  AST_UV_LO_FAULT: assert property (@(posedge clk) disable iff (rst)
    uv_lo |-> !fault_n); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (gate_hi == 3'b000 && gate_lo == 3'b000)); // R11
endmodule

// File: tb/inv_gate_guard_test.sv
`timescale 1ns/1ps
module inv_gate_guard_test;
  localparam int CW = 8, FILT = 3, PULSE = 20;
  localparam int LOT = 100, LOR = 120, HIT = 90, HIR = 110;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] pwm_hi, pwm_lo, gate_hi, gate_lo;
  logic oc_in, fault_n;
  logic [CW-1:0] vd_lo;
  logic [3*CW-1:0] vd_hi;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inv_gate_guard #(.CW(CW), .FILT_CYC(FILT), .PULSE_CYC(PULSE),
    .LO_TRIP(LOT), .LO_REL(LOR), .HI_TRIP(HIT), .HI_REL(HIR)) uut (
    .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .oc_in(oc_in),
    .vd_lo(vd_lo), .vd_hi(vd_hi), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .fault_n(fault_n));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rearm_lo();
    pwm_lo = 3'b000; step(1); pwm_lo = 3'b111; step(1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    int w;
    rst = 1; pwm_hi = 3'b111; pwm_lo = 3'b111; oc_in = 0;
    vd_lo = 200; vd_hi = {3{8'd200}};
    step(3); rst = 0;
    step(1);
    chk("R11 gates after reset", {gate_hi, gate_lo}, 0);
    chk("R11 fault released", fault_n, 1);
    step(3);
    chk("R11 held command stays off", {gate_hi, gate_lo}, 0);

    // R1: arm all, then sweep every 6-bit command pattern
    pwm_hi = 0; pwm_lo = 0; step(1);
    pwm_hi = 3'b111; pwm_lo = 3'b111; step(1);
    chk("R1 armed after fresh edge", {gate_hi, gate_lo}, 63);
    for (int v = 0; v < 64; v++) begin
      {pwm_hi, pwm_lo} = 6'(v); step(1);
      chk("R1 follow pattern", {gate_hi, gate_lo}, v);
    end
    pwm_hi = 3'b111; pwm_lo = 3'b111; step(2);

    // R2: runs shorter than the filter do nothing
    for (int len = 1; len < FILT; len++) begin
      oc_in = 1; step(len); oc_in = 0; step(2);
      chk("R2 short run gates", gate_lo, 7);
      chk("R2 short run fault", fault_n, 1);
    end

    // R3/R5: confirmed trip
    oc_in = 1; step(FILT);
    chk("R3 not yet off", gate_lo, 7);
    step(1);
    chk("R3 low gates off", gate_lo, 0);
    chk("R3 high gates kept", gate_hi, 7);
    w = 0;
    while (!fault_n && w < 200) begin w++; step(1); end
    chk("R5 pulse width", w, PULSE);
    chk("R4 blocked while flag held", gate_lo, 0);
    oc_in = 0; step(3);
    chk("R4 stays off with command high", gate_lo, 0);
    rearm_lo();
    chk("R4 rearm after fresh edge", gate_lo, 7);
    step(5);

    // R6: second trip inside running pulse
    w = 0;
    for (int k = 0; k < 60; k++) begin
      oc_in = (k < 5) || (k >= 7 && k < 13);
      step(1);
      if (!fault_n) w++;
    end
    chk("R6 no extension", w, PULSE);
    rearm_lo();
    chk("R6 rearm", gate_lo, 7);

    // R7/R8: long under-voltage held by hysteresis band
    w = 0;
    for (int k = 0; k < 80; k++) begin
      vd_lo = (k == 0) ? 8'd90 : (k < 40 ? 8'd110 : 8'd200);
      step(1);
      if (!fault_n) w++;
      if (k == 30) chk("R8 low gates off in UV", gate_lo, 0);
    end
    chk("R7 fault over whole UV", w, 40);
    chk("R9 no resume mid pulse", gate_lo, 0);
    rearm_lo();
    chk("R9 resume on next edge", gate_lo, 7);

    // R8: single-cycle dip
    w = 0;
    for (int k = 0; k < 40; k++) begin
      vd_lo = (k == 0) ? 8'd90 : 8'd200;
      step(1);
      if (!fault_n) w++;
    end
    chk("R8 minimum width", w, PULSE + 1);
    rearm_lo();

    // R7: threshold points on the low side
    for (int c = LOT - 1; c <= LOT; c++) begin
      vd_lo = 8'(c); step(1);
      chk("R7 trip point", fault_n, (c >= LOT) ? 1 : 0);
      vd_lo = 200; step(30); rearm_lo();
    end
    for (int c = LOR; c <= LOR + 1; c++) begin
      vd_lo = 0; step(1); vd_lo = 8'(c); step(30);
      chk("R7 release point", fault_n, (c > LOR) ? 1 : 0);
      vd_lo = 200; step(30); rearm_lo();
    end

    // R10: full code sweep on phase 1, both starting states
    for (int c = 0; c < 256; c++) begin
      vd_hi = {8'd200, 8'd200, 8'd200}; step(2);
      pwm_hi = 3'b101; step(1); pwm_hi = 3'b111; step(1);
      vd_hi = {8'd200, 8'(c), 8'd200}; step(2);
      chk("R10 trip sweep", gate_hi, (c >= HIT) ? 7 : 5);
      chk("R10 no fault", fault_n, 1);
    end
    for (int c = 0; c < 256; c++) begin
      vd_hi = {8'd200, 8'd0, 8'd200}; step(2);
      vd_hi = {8'd200, 8'(c), 8'd200}; step(2);
      pwm_hi = 3'b101; step(1); pwm_hi = 3'b111; step(1);
      chk("R10 release sweep", gate_hi, (c > HIR) ? 7 : 5);
    end
    chk("R10 low side untouched", gate_lo, 7);

    done = 1;
    summary();
  end
endmodule